// File: doc/BRIEF.md
# Capture/Compare Timer Unit

This block is a free-running up-counter shared by four channel registers. The counter advances on enable pulses from a prescaler. The prescaler divides the system clock by 2, 4, 8, 16 or 32, as chosen by a select field. A run bit starts and stops both the counter and the prescaler.

Each channel has its own mode bit, which can be changed while the timer runs. A channel in compare mode raises a one-cycle interrupt request and a match strobe when its value equals a freshly updated count. A channel in capture mode copies the counter into its register when its capture-trigger input pulses. The triggers arrive already edge-detected, and the match strobes go to separate output-shaping logic.

A small word-wide register port gives access to the control word, the counter (read-only) and the four channel values. Reads are combinational from the address.

Top module: `cct_timer`

## Requirements
- R1: The counter increases by exactly one on each prescaler enable pulse and wraps from all-ones to zero without stopping.
- R2: After reset the counter reads 0, the control word reads 0, no interrupt is raised, and the counter holds its value for as long as the run bit (control bit 0) is 0.
- R3: Address 1 reads the counter. A write to address 1 leaves the counter unchanged.
- R4: Control bits 3:1 select the division: values 0, 1, 2, 3 and 4 give divide-by 2, 4, 8, 16 and 32, and values 5, 6 and 7 also give divide-by 32. When the run bit is set from stopped, the first increment occurs exactly one division period after the write edge.
- R5: A channel in compare mode (its mode bit is 0) that has been written since reset raises its interrupt bit and its match-strobe bit for exactly one cycle. This happens in the cycle after the counter takes a value equal to the channel value, so each equality fires once.
- R6: A channel in capture mode (control bit 4+i is 1) loads the counter value present at the trigger edge when its capture-trigger bit is high. It keeps that value until the next trigger and never raises an interrupt.
- R7: While the run bit is 0, capture triggers leave the channel registers unchanged.
- R8: Address 0 reads back the control word written to it. Addresses 2 to 5 read and write channels 0 to 3. Addresses 6 and 7 read 0.
- R9: When a register write and a capture trigger hit the same channel in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for regAddr |
| capTrig | input | 4 | Capture-trigger pulse per channel |
| irqReq | output | 4 | One-cycle interrupt request per channel |
| matchStrobe | output | 4 | One-cycle compare-match strobe per channel |

## Verification
The bench builds the block with DATA_W set to 8 instead of 16. With that width the counter wraps after 256 increments, so a full wrap at the fastest division takes about 512 cycles. This lets the bench watch the counter value on every cycle across the wrap, including a compare match at count zero right after it. All eight select codes are walked, so the aliased codes 5 to 7 and the slowest division are covered within the cycle budget.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CCT_CH = 4;
  localparam int CCT_SEL_W = 3;
  localparam int CCT_CTRL_W = 4 + CCT_CH;

  typedef struct packed {
    logic              run;
    logic              tick;
    logic [CCT_CH-1:0] capMode;
    logic [CCT_CH-1:0] chWr;
  } cct_strobe_t;
endpackage

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int NUM_DIV = 5,
  parameter int CH_BASE = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWrEn,
  input  logic [CCT_CTRL_W-1:0]    ctrlWrData,
  input  logic [DATA_W-1:0]        countVal,
  input  logic [CCT_CH*DATA_W-1:0] chFlat,
  output logic [DATA_W-1:0]        regRdData,
  output cct_strobe_t              strobe
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'(1);

  logic                 runQ;
  logic [CCT_SEL_W-1:0] selQ;
  logic [CCT_CH-1:0]    capModeQ;
  logic [NUM_DIV-1:0]   divCnt;
  logic [NUM_DIV-1:0]   divMask;
  int                   effSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      selQ     <= '0;
      capModeQ <= '0;
    end else if (regWrEn && regAddr == CTRL_ADDR) begin
      runQ     <= ctrlWrData[0];
      selQ     <= ctrlWrData[3:1];
      capModeQ <= ctrlWrData[4 +: CCT_CH];
    end
  end

  // prescaler: cleared while stopped, free-running while enabled
  always_ff @(posedge clk) begin
    if (!rstN || !runQ) divCnt <= '0;
    else                divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    effSel = (int'(selQ) >= NUM_DIV) ? NUM_DIV - 1 : int'(selQ);
    for (int k = 0; k < NUM_DIV; k++) divMask[k] = (k <= effSel);
  end

  always_comb begin
    strobe.run     = runQ;
    strobe.capMode = capModeQ;
    strobe.tick    = runQ && ((divCnt & divMask) == divMask);
    for (int i = 0; i < CCT_CH; i++)
      strobe.chWr[i] = regWrEn && (regAddr == ADDR_W'(CH_BASE + i));
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdData[0]             = runQ;
      regRdData[3:1]           = selQ;
      regRdData[4 +: CCT_CH]   = capModeQ;
    end else if (regAddr == COUNT_ADDR) begin
      regRdData = countVal;
    end else begin
      for (int i = 0; i < CCT_CH; i++)
        if (regAddr == ADDR_W'(CH_BASE + i)) regRdData = chFlat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cct_strobe_t              strobe,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [CCT_CH-1:0]        capTrig,
  output logic [DATA_W-1:0]        countVal,
  output logic [CCT_CH*DATA_W-1:0] chFlat,
  output logic [CCT_CH-1:0]        irqReq
);
  logic [DATA_W-1:0] countQ;
  logic              updQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      updQ   <= 1'b0;
    end else begin
      updQ <= strobe.tick;
      if (strobe.tick) countQ <= countQ + 1'b1;
    end
  end

  assign countVal = countQ;

  for (genvar i = 0; i < CCT_CH; i++) begin : g_ch
    logic [DATA_W-1:0] chQ;
    logic              armedQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chQ    <= '0;
        armedQ <= 1'b0;
      end else if (strobe.chWr[i]) begin
        chQ    <= wrData;
        armedQ <= 1'b1;
      end else if (strobe.run && strobe.capMode[i] && capTrig[i]) begin
        chQ <= countQ;
      end
    end

    assign chFlat[i*DATA_W +: DATA_W] = chQ;
    assign irqReq[i] = updQ && armedQ && !strobe.capMode[i] && (chQ == countQ);
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [3:0]        capTrig,
  output logic [3:0]        irqReq,
  output logic [3:0]        matchStrobe
);
  cct_strobe_t              strobe;
  logic [DATA_W-1:0]        countW;
  logic [CCT_CH*DATA_W-1:0] chFlatW;
  logic                     runW;
  logic [CCT_CH-1:0]        capModeW;
  logic [CCT_CH-1:0]        chWrW;

  cct_ctrl #(.DATA_W(DATA_W), .ADDR_W(3), .NUM_DIV(5), .CH_BASE(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .ctrlWrData(regWrData[CCT_CTRL_W-1:0]), .countVal(countW), .chFlat(chFlatW),
    .regRdData(regRdData), .strobe(strobe)
  );

  cct_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData), .capTrig(capTrig),
    .countVal(countW), .chFlat(chFlatW), .irqReq(irqReq)
  );

  assign matchStrobe = irqReq;
  assign runW        = strobe.run;
  assign capModeW    = strobe.capMode;
  assign chWrW       = strobe.chWr;
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int DATA_W = 16,
  parameter int NCH    = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  run,
  input logic [NCH-1:0]        capMode,
  input logic [NCH-1:0]        chWr,
  input logic [NCH-1:0]        capTrig,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     count,
  input logic [NCH*DATA_W-1:0] chFlat,
  input logic [NCH-1:0]        irq
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == DATA_W'($past(count) + 1'b1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(count));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_fresh_r5: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> (count != $past(count)));

    p_equal_r5: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> (chFlat[i*DATA_W +: DATA_W] == count && !capMode[i]));

    p_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
      (run && capMode[i] && capTrig[i] && !chWr[i]) |=>
        (chFlat[i*DATA_W +: DATA_W] == $past(count)));

    p_stopped_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!run && !chWr[i]) |=> $stable(chFlat[i*DATA_W +: DATA_W]));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      chWr[i] |=> (chFlat[i*DATA_W +: DATA_W] == $past(wrData)));
  end
endmodule

bind cct_timer cct_checker #(.DATA_W(DATA_W), .NCH(4)) u_chk (
  .clk(clk), .rstN(rstN), .run(runW), .capMode(capModeW), .chWr(chWrW),
  .capTrig(capTrig), .wrData(regWrData), .count(countW), .chFlat(chFlatW),
  .irq(irqReq)
);

// File: tb/tb_cct_timer.sv
module tb_cct_timer;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    regAddr;
  logic          regWrEn;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic [3:0]    capTrig;
  logic [3:0]    irqReq;
  logic [3:0]    matchStrobe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cct_timer #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .capTrig(capTrig),
    .irqReq(irqReq), .matchStrobe(matchStrobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 3'd1; regWrData = '0; capTrig = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    regAddr = 3'(a); regWrData = DW'(d); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd1;
  endtask

  task automatic rdReg(input int a, output int v);
    regAddr = 3'(a);
    #1;
    v = int'(regRdData);
  endtask

  task automatic testReset();
    int v;
    doReset();
    rdReg(1, v); chk("R2 count after reset", v, 0);
    rdReg(0, v); chk("R2 ctrl after reset", v, 0);
    chk("R2 no irq after reset", int'(irqReq), 0);
    repeat (10) @(negedge clk);
    rdReg(1, v); chk("R2 count held while stopped", v, 0);
    rdReg(7, v); chk("R8 unmapped address reads 0", v, 0);
  endtask

  task automatic testPrescale();
    int v;
    for (int sel = 0; sel < 8; sel++) begin
      int div;
      div = 2 << ((sel > 4) ? 4 : sel);
      doReset();
      wrReg(0, 1 | (sel << 1));
      repeat (div - 1) @(negedge clk);
      rdReg(1, v); chk($sformatf("R4 sel %0d before first step", sel), v, 0);
      @(negedge clk);
      rdReg(1, v); chk($sformatf("R4 sel %0d first step", sel), v, 1);
      repeat (2 * div) @(negedge clk);
      rdReg(1, v); chk($sformatf("R4 sel %0d third step", sel), v, 3);
    end
  endtask

  task automatic testCompare();
    int v;
    doReset();
    wrReg(2, 5);
    wrReg(4, 0);
    wrReg(5, 5);
    wrReg(0, 'h81);
    rdReg(0, v); chk("R8 ctrl readback", v, 'h81);
    rdReg(2, v); chk("R8 channel 0 readback", v, 5);
    regAddr = 3'd1;
    for (int m = 1; m <= 530; m++) begin
      int expIrq;
      @(negedge clk);
      #1;
      chk("R1 count per cycle incl wrap", int'(regRdData), (m / 2) % 256);
      expIrq = ((m == 10 || m == 522) ? 1 : 0) | ((m == 512) ? 4 : 0);
      chk("R5 R6 irq pattern", int'(irqReq), expIrq);
      chk("R5 match strobe pattern", int'(matchStrobe), expIrq);
    end
  endtask

  task automatic testCapture();
    int v, c1;
    doReset();
    wrReg(0, 'hF1);
    repeat (20) @(negedge clk);
    capTrig = 4'b0010;
    @(negedge clk);
    capTrig = 4'b0000;
    repeat (10) @(negedge clk);
    rdReg(3, v); chk("R6 captured value", v, 10);
    chk("R6 no irq in capture mode", int'(irqReq), 0);
    repeat (40) @(negedge clk);
    rdReg(3, v); chk("R6 value held", v, 10);
    // write and capture on channel 0 in the same cycle
    @(negedge clk);
    regAddr = 3'd2; regWrData = DW'('h77); regWrEn = 1'b1; capTrig = 4'b0001;
    @(negedge clk);
    regWrEn = 1'b0; capTrig = 4'b0000; regAddr = 3'd1;
    rdReg(2, v); chk("R9 write beats capture", v, 'h77);
    // stop, then trigger channel 2
    wrReg(0, 'hF0);
    rdReg(1, c1);
    @(negedge clk);
    capTrig = 4'b0100;
    @(negedge clk);
    capTrig = 4'b0000;
    repeat (5) @(negedge clk);
    rdReg(4, v); chk("R7 trigger ignored while stopped", v, 0);
    rdReg(1, v); chk("R2 count held after stop", v, c1);
    wrReg(1, 'h55);
    rdReg(1, v); chk("R3 counter write ignored", v, c1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testPrescale();
    testCompare();
    testCapture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule